// File: doc/BRIEF.md
# Interrupt enable and status controller

This block holds the interrupt configuration and pending state of a command-buffer device. Four event strobes (data available, status valid, locality change, command ready) come from the device core. Each strobe sets its own sticky bit in a status register. Software clears those bits by writing ones to them. A per-source enable mask and a global enable gate the pending bits onto a single interrupt line. The electrical style of that line is set in the enable register and can be level-high, level-low, a rising pulse or a falling pulse.

Software reaches the registers through a plain 32-bit port. The port takes a write strobe with its data and gives back read data for the addressed word without delay. Besides the enable and status words there is an 8-bit vector word, which holds the system interrupt number. The block only stores that number and does not route it anywhere. A read-only capability word tells software which output styles this instance supports. Output styles that are not built can never be selected.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the enable, status and vector words read 0, the output style is level-high and `irq_out` is low.
- R2: The enable word is at offset 0x08, the vector at 0x0C, the status at 0x10 and the capability at 0x14. Any other offset reads 0. The vector keeps only bits [7:0] of a write. In the enable word, bit 31 is the global enable, bits [4:3] are the style field and bits 7, 2, 1 and 0 are the source enables. All other enable bits read 0.
- R3: Each event strobe sets one sticky status bit, whatever the enables are: data available sets 0x001, status valid sets 0x002, locality change sets 0x004 and command ready sets 0x080. The bit stays set until it is cleared.
- R4: A write to the status word clears exactly the status bits written as 1 and leaves every other bit unchanged. A write to the status word never sets a bit.
- R5: An event that arrives in the same cycle as a write that clears its bit leaves that bit set.
- R6: The interrupt is pending when the global enable is 1 and (status & enable[7:0]) is nonzero. While the global enable is 0, `irq_out` stays at its idle level: 0 for the level-high and rising styles, 1 for the level-low and falling styles.
- R7: Style 2'b00 (level-high) drives `irq_out` equal to the pending state. Style 2'b01 (level-low) drives its inverse.
- R8: Style 2'b10 (rising) drives `irq_out` high for exactly one cycle each time the pending state goes from 0 to 1, and low at all other times. Style 2'b11 (falling) drives a one-cycle low pulse at the same point and is high at all other times. The pulse appears in the cycle right after the clock edge that latches the event.
- R9: The capability word is fixed by parameters and writes to it have no effect. Its bits are: burst-count-static 0x100, command-ready 0x080, falling 0x040, rising 0x020, level-low 0x010, level-high 0x008, locality-change 0x004, status-valid 0x002 and data-available 0x001. With all options built, the word reads 0x1FF.
- R10: A write of an enable word whose style field names a style that is not built leaves the style unchanged. The global enable and source enable bits of that same write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register offset for both read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_data_avail | input | 1 | Data-available event strobe |
| ev_sts_valid | input | 1 | Status-valid event strobe |
| ev_loc_change | input | 1 | Locality-change event strobe |
| ev_cmd_ready | input | 1 | Command-ready event strobe |
| irq_out | output | 1 | Interrupt line in the selected style |

## Verification
Directed steps come first and cover these cases:
- events arriving with all enables off, to tell sticky latching apart from gating;
- a clear write that hits only some of the set bits, to expose a clear that is too wide;
- an event that lands on the same bit as a clear in the same cycle, to check the set-wins rule;
- each of the four output styles, with the pulse styles checked on both the cycle the event is latched and the cycle after it.

A second instance built without the level-low and falling styles shows whether an unsupported style write is refused while its enable bits are still taken. After that, a long random mix of enable, status and vector writes runs against independent events, checking the line on every cycle. This mix reaches overlapping pending sources, style changes while an interrupt is pending and enables toggled under pending status.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   // register offsets (byte addresses)
   localparam int OFS_ENABLE = 'h08;
   localparam int OFS_VECTOR = 'h0C;
   localparam int OFS_STATUS = 'h10;
   localparam int OFS_CAPS   = 'h14;

   // enable word layout
   localparam int GLOBAL_BIT = 31;
   localparam int MODE_LSB   = 3;

   // event sources and their bit positions in enable/status words
   localparam int NUM_SRC = 4;
   localparam int SRC_POS [NUM_SRC] = '{0, 1, 2, 7};

   typedef enum logic [1:0] {
      STYLE_LVL_HI = 2'b00,
      STYLE_LVL_LO = 2'b01,
      STYLE_RISE   = 2'b10,
      STYLE_FALL   = 2'b11
   } irq_style_e;

endpackage

// File: rtl/evt_irq_status.sv
module evt_irq_status
   import evt_irq_pkg::*;
#(
   parameter int NSRC = NUM_SRC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] sts
);

   if (NSRC < 1) begin : g_bad_nsrc
      $error("evt_irq_status: NSRC must be at least 1");
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_bit
      // set has priority over clear so a coincident event is never lost
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sts[g] <= 1'b0;
         else if (evt[g])
            sts[g] <= 1'b1;
         else if (clr[g])
            sts[g] <= 1'b0;
      end

      // R3 R5
      evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[g] |=> sts[g]);

      // R4
      clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[g] && !evt[g]) |=> !sts[g]);

      // R3
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sts[g] && !clr[g]) |=> sts[g]);
   end

endmodule

// File: rtl/evt_irq_cfg.sv
module evt_irq_cfg
   import evt_irq_pkg::*;
#(
   parameter int NSRC      = NUM_SRC,
   parameter int VEC_W     = 8,
   parameter bit SUP_LO    = 1'b1,
   parameter bit SUP_RISE  = 1'b1,
   parameter bit SUP_FALL  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic             vec_wr,
   input  logic [31:0]      wdata,
   output logic [NSRC-1:0]  src_en,
   output logic             glob_en,
   output irq_style_e       style,
   output logic [VEC_W-1:0] vec
);

   if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec
      $error("evt_irq_cfg: VEC_W must be 1..8");
   end

   function automatic logic style_built(input logic [1:0] s);
      case (s)
         STYLE_LVL_HI: return 1'b1;
         STYLE_LVL_LO: return SUP_LO;
         STYLE_RISE:   return SUP_RISE;
         default:      return SUP_FALL;
      endcase
   endfunction

   logic [1:0] style_req;
   logic       style_ok;
   logic       unused_wbits;

   assign style_req    = wdata[MODE_LSB +: 2];
   assign style_ok     = style_built(style_req);
   assign unused_wbits = ^{wdata[30:8], wdata[6:5]};

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            src_en[g] <= 1'b0;
         else if (en_wr)
            src_en[g] <= wdata[SRC_POS[g]];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en <= 1'b0;
         style   <= STYLE_LVL_HI;
      end else if (en_wr) begin
         glob_en <= wdata[GLOBAL_BIT];
         if (style_ok)
            style <= irq_style_e'(style_req);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vec <= '0;
      else if (vec_wr)
         vec <= wdata[VEC_W-1:0];
   end

   // R10
   style_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && !style_ok) |=> $stable(style));

   // R10
   style_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      style_built(style));

endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out
   import evt_irq_pkg::*;
#(
   parameter bit HAS_EDGE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pending,
   input  irq_style_e style,
   output logic       irq
);

   logic pend_d;
   logic fresh;

   if (HAS_EDGE) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_d <= 1'b0;
         else
            pend_d <= pending;
      end
   end else begin : g_no_edge
      assign pend_d = 1'b1;
   end

   assign fresh = pending & ~pend_d;

   always_comb begin
      case (style)
         STYLE_LVL_HI: irq = pending;
         STYLE_LVL_LO: irq = ~pending;
         STYLE_RISE:   irq = fresh;
         default:      irq = ~fresh;
      endcase
   end

   // R8
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (style == STYLE_RISE && irq) |=> (!irq || style != STYLE_RISE));

   // R8
   fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (style == STYLE_FALL && !irq) |=> (irq || style != STYLE_FALL));

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int VEC_W        = 8,
   parameter bit BURST_STATIC = 1'b1,
   parameter bit SUP_LVL_LO   = 1'b1,
   parameter bit SUP_RISE     = 1'b1,
   parameter bit SUP_FALL     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              ev_data_avail,
   input  logic              ev_sts_valid,
   input  logic              ev_loc_change,
   input  logic              ev_cmd_ready,
   output logic              irq_out
);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("evt_irq_ctrl: ADDR_W must be at least 5");
   end

   localparam logic [31:0] CAPS_WORD =
        (BURST_STATIC ? 32'h100 : 32'h0)
      | 32'h080
      | (SUP_FALL     ? 32'h040 : 32'h0)
      | (SUP_RISE     ? 32'h020 : 32'h0)
      | (SUP_LVL_LO   ? 32'h010 : 32'h0)
      | 32'h008
      | 32'h007;
   localparam bit HAS_EDGE = SUP_RISE | SUP_FALL;

   logic               sel_en, sel_vec, sel_sts, sel_caps;
   logic [NUM_SRC-1:0] evt, clr, sts, src_en;
   logic               glob_en, pending;
   irq_style_e         style;
   logic [VEC_W-1:0]   vec;
   logic [31:0]        sts_word, en_word;

   assign sel_en   = (reg_addr == ADDR_W'(OFS_ENABLE));
   assign sel_vec  = (reg_addr == ADDR_W'(OFS_VECTOR));
   assign sel_sts  = (reg_addr == ADDR_W'(OFS_STATUS));
   assign sel_caps = (reg_addr == ADDR_W'(OFS_CAPS));

   assign evt = {ev_cmd_ready, ev_loc_change, ev_sts_valid, ev_data_avail};

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
      assign clr[g] = reg_wr & sel_sts & reg_wdata[SRC_POS[g]];
   end

   evt_irq_status #(.NSRC(NUM_SRC)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .clr   (clr),
      .sts   (sts)
   );

   evt_irq_cfg #(
      .NSRC     (NUM_SRC),
      .VEC_W    (VEC_W),
      .SUP_LO   (SUP_LVL_LO),
      .SUP_RISE (SUP_RISE),
      .SUP_FALL (SUP_FALL)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_wr   (reg_wr & sel_en),
      .vec_wr  (reg_wr & sel_vec),
      .wdata   (reg_wdata),
      .src_en  (src_en),
      .glob_en (glob_en),
      .style   (style),
      .vec     (vec)
   );

   assign pending = glob_en & (|(sts & src_en));

   evt_irq_out #(.HAS_EDGE(HAS_EDGE)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (pending),
      .style   (style),
      .irq     (irq_out)
   );

   always_comb begin
      sts_word = '0;
      en_word  = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         sts_word[SRC_POS[i]] = sts[i];
         en_word[SRC_POS[i]]  = src_en[i];
      end
      en_word[GLOBAL_BIT]      = glob_en;
      en_word[MODE_LSB +: 2]   = style;
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_en)   reg_rdata = en_word;
      if (sel_vec)  reg_rdata = 32'(vec);
      if (sel_sts)  reg_rdata = sts_word;
      if (sel_caps) reg_rdata = CAPS_WORD;
   end

   // R6
   global_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |-> (irq_out == (style == STYLE_LVL_LO || style == STYLE_FALL)));

   // R7
   level_hi_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (style == STYLE_LVL_HI && glob_en && |(sts & src_en)) |-> irq_out);

endmodule

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, rdata_nf;
   logic [3:0]  ev = '0;
   logic        irq_out, irq_nf;
   logic        done = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   evt_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]), .ev_loc_change(ev[2]),
      .ev_cmd_ready(ev[3]), .irq_out(irq_out));

   evt_irq_ctrl #(.SUP_LVL_LO(1'b0), .SUP_FALL(1'b0)) uut_nf (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_nf),
      .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]), .ev_loc_change(ev[2]),
      .ev_cmd_ready(ev[3]), .irq_out(irq_nf));

   // reference model of the default instance
   logic [7:0] m_src, m_sts, m_vec;
   logic       m_glob, m_pd;
   logic [1:0] m_mode;

   function automatic logic m_pend();
      return m_glob && ((m_sts & m_src) != 8'h0);
   endfunction

   function automatic logic m_irq();
      logic p;
      p = m_pend();
      case (m_mode)
         2'b00:   return p;
         2'b01:   return !p;
         2'b10:   return p && !m_pd;
         default: return !(p && !m_pd);
      endcase
   endfunction

   function automatic logic [31:0] m_en_word();
      return {m_glob, 23'h0, m_src[7], 2'b00, m_mode, m_src[2:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // one clock cycle, called at a falling edge; checks irq_out afterwards
   task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [3:0] e);
      logic [7:0] evm, clrm;
      reg_wr = wr; reg_addr = a; reg_wdata = d; ev = e;
      @(posedge clk);
      m_pd = m_pend();
      evm  = {e[3], 4'b0000, e[2], e[1], e[0]};
      clrm = (wr && a == 8'h10) ? (d[7:0] & 8'h87) : 8'h00;
      m_sts = (m_sts & ~clrm) | evm;
      if (wr && a == 8'h08) begin
         m_src  = d[7:0] & 8'h87;
         m_glob = d[31];
         m_mode = d[4:3];
      end
      if (wr && a == 8'h0C) m_vec = d[7:0];
      @(negedge clk);
      reg_wr = 1'b0; ev = '0;
      if (!m_glob)             chk("R6 irq idle", 32'(irq_out), 32'(m_irq()));
      else if (m_mode[1])      chk("R8 irq pulse", 32'(irq_out), 32'(m_irq()));
      else                     chk("R7 irq level", 32'(irq_out), 32'(m_irq()));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      m_src = 0; m_sts = 0; m_vec = 0; m_glob = 0; m_pd = 0; m_mode = 0;
      void'($urandom(32'd1977));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h08, d); chk("R1 enable", d, 32'h0);
      rd(8'h10, d); chk("R1 status", d, 32'h0);
      rd(8'h0C, d); chk("R1 vector", d, 32'h0);
      chk("R1 irq_out", 32'(irq_out), 32'h0);
      // R9 capability words
      rd(8'h14, d); chk("R9 caps full", d, 32'h1FF);
      chk("R9 caps reduced", rdata_nf, 32'h1AF);
      // R2 unmapped offset
      rd(8'h04, d); chk("R2 unmapped", d, 32'h0);

      // R2 vector keeps low byte
      step(1, 8'h0C, 32'h1234_56A5, 4'h0);
      rd(8'h0C, d); chk("R2 vector", d, 32'hA5);
      // R9 write to caps ignored
      step(1, 8'h14, 32'h0, 4'h0);
      rd(8'h14, d); chk("R9 caps write", d, 32'h1FF);

      // R3 events latch with enables off
      step(0, 8'h00, 32'h0, 4'hF);
      rd(8'h10, d); chk("R3 sticky set", d, 32'h87);
      step(0, 8'h00, 32'h0, 4'h0);
      rd(8'h10, d); chk("R3 sticky hold", d, 32'h87);
      // R4 partial clear; status write cannot set
      step(1, 8'h10, 32'h05, 4'h0);
      rd(8'h10, d); chk("R4 w1c", d, 32'h82);
      step(1, 8'h10, 32'h0, 4'h0);
      rd(8'h10, d); chk("R4 zero write", d, 32'h82);
      // R5 coincident event and clear
      step(1, 8'h10, 32'h02, 4'b0010);
      rd(8'h10, d); chk("R5 set wins", d, 32'h82);

      // R6 source enabled without global
      step(1, 8'h08, 32'h0000_0080, 4'h0);
      chk("R6 no global", 32'(irq_out), 32'h0);
      // R7 level high then level low; R10 on reduced instance
      step(1, 8'h08, 32'h8000_0080, 4'h0);
      chk("R7 level high", 32'(irq_out), 32'h1);
      step(1, 8'h08, 32'h8000_0088, 4'h0);
      chk("R7 level low", 32'(irq_out), 32'h0);
      rd(8'h08, d); chk("R2 enable layout", d, 32'h8000_0088);
      chk("R10 refused style", rdata_nf, 32'h8000_0080);
      chk("R10 level kept", 32'(irq_nf), 32'h1);
      // R2 unused enable bits
      step(1, 8'h08, 32'h7FFF_FF60, 4'h0);
      rd(8'h08, d); chk("R2 enable masked", d, 32'h0);

      // R8 rising pulse
      step(1, 8'h10, 32'hFF, 4'h0);
      step(1, 8'h08, 32'h8000_0011, 4'h0);
      chk("R8 rise idle", 32'(irq_out), 32'h0);
      step(0, 8'h00, 32'h0, 4'b0001);
      chk("R8 rise pulse", 32'(irq_out), 32'h1);
      step(0, 8'h00, 32'h0, 4'b0001);
      chk("R8 rise end", 32'(irq_out), 32'h0);
      // R8 falling pulse
      step(1, 8'h10, 32'hFF, 4'h0);
      step(1, 8'h08, 32'h8000_0019, 4'h0);
      chk("R8 fall idle", 32'(irq_out), 32'h1);
      step(0, 8'h00, 32'h0, 4'b0001);
      chk("R8 fall pulse", 32'(irq_out), 32'h0);
      step(0, 8'h00, 32'h0, 4'h0);
      chk("R8 fall end", 32'(irq_out), 32'h1);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op;
         logic [3:0] e;
         logic [31:0] w;
         op = $urandom_range(0, 5);
         e  = 4'($urandom) & 4'($urandom);
         w  = $urandom;
         case (op)
            0:       step(1, 8'h08, w, e);
            1:       step(1, 8'h10, w, e);
            2:       step(1, 8'h0C, w, e);
            default: step(0, 8'h00, w, e);
         endcase
         if (i % 4 == 3) begin
            rd(8'h10, d); chk("R3 R4 R5 status", d, 32'(m_sts));
            rd(8'h08, d); chk("R2 enable", d, m_en_word());
            rd(8'h0C, d); chk("R2 vector", d, 32'(m_vec));
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule